// File: doc/BRIEF.md
# Incremental PID Gain Controller

This block is the control half of an automatic gain control loop. Each time the upstream magnitude estimator presents a new amplitude sample, the block subtracts that sample from a programmable target level. From the resulting error and the two errors before it, it forms a gain increment in velocity form. It then adds that increment to a held gain word, which drives a digital gain stage further down the chain.

Three terms make up the increment. The proportional term acts on the first difference of the error, so a sudden jump in the input level shows up at once. The integral term acts on the error itself and pulls the level onto the target. The derivative term acts on the second difference of the error and damps the gain steps, which keeps the output from overshooting when the input envelope rises or collapses. Each coefficient is a right-shift amount, so the update needs adders only. The gain is bounded by programmable minimum and maximum limits.

Top module: `agc_pid_ctrl`

## Requirements
- R1: While reset is asserted and until the first update after release, `gain_out` equals `gain_init`. Reset clears both stored errors to zero.
- R2: In a cycle where `amp_valid` is low, `gain_out` and the stored error history keep their values.
- R3: The error is the signed difference `target - amp_in`, one bit wider than the amplitude, with both operands treated as unsigned. A sample above the target gives a negative error.
- R4: The increment is `((e - e1) >>> kp_shift) + (e >>> ki_shift) + ((e - 2*e1 + e2) >>> kd_shift)`. Each `>>>` is an arithmetic shift that rounds toward minus infinity. `e1` and `e2` are the previous two errors.
- R5: Every accepted sample shifts the history: `e2` takes the old `e1`, and `e1` takes the new error.
- R6: An update takes effect at the clock edge that samples `amp_valid` high. The new gain is visible right after that edge, and not before it.
- R7: When the base gain plus the increment exceeds `gain_max`, the gain becomes `gain_max`.
- R8: When the base gain plus the increment falls below `gain_min`, the gain becomes `gain_min`.
- R9: A gain at or above `gain_max` ignores a positive increment, and a gain at or below `gain_min` ignores a negative increment. An increment in the opposite direction moves the gain off the limit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| amp_valid | input | 1 | Strobe marking a new amplitude sample |
| amp_in | input | AMP_W | Measured amplitude, unsigned |
| target | input | AMP_W | Desired amplitude level, unsigned |
| kp_shift | input | SHIFT_W | Right-shift amount for the proportional term |
| ki_shift | input | SHIFT_W | Right-shift amount for the integral term |
| kd_shift | input | SHIFT_W | Right-shift amount for the derivative term |
| gain_init | input | GAIN_W | Gain presented from reset until the first update |
| gain_min | input | GAIN_W | Lower gain limit |
| gain_max | input | GAIN_W | Upper gain limit |
| gain_out | output | GAIN_W | Gain word for the gain stage |

## Verification
The bench builds the block with an 8-bit amplitude and a 10-bit gain word. With a target of 100 and shifts of 1 and 2, a full-scale error moves the gain by tens of counts per sample. Both limits can therefore be reached from mid-range within a few dozen samples. This means one run covers the clamp at each limit, holding at the limit, and moving back off it. It also covers a second reset that loads a new initial gain and clears the history. The narrow widths still leave both error signs and every rounding case of the arithmetic shifts in play.

// File: rtl/agc_pid_pkg.sv
package agc_pid_pkg;

  // Action chosen by the gain accumulator in one cycle.
  typedef enum logic [2:0] {
    ACC_IDLE     = 3'd0,
    ACC_LOAD     = 3'd1,
    ACC_ADD      = 3'd2,
    ACC_HOLD     = 3'd3,
    ACC_CLAMP_HI = 3'd4,
    ACC_CLAMP_LO = 3'd5
  } acc_act_e;

  // Number of increment terms (proportional, integral, derivative).
  localparam int unsigned NUM_TERMS = 3;

  // Bits needed to hold a sum of up to four operands of width w.
  function automatic int unsigned sum4_width(input int unsigned w);
    return w + 2;
  endfunction

endpackage

// File: rtl/agc_err_hist.sv
module agc_err_hist #(
  parameter int unsigned AMP_W = 16,
  parameter int unsigned ERR_W = AMP_W + 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    upd,
  input  logic [AMP_W-1:0]        amp,
  input  logic [AMP_W-1:0]        target,
  output logic signed [ERR_W-1:0] err_now,
  output logic signed [ERR_W-1:0] err_d1,
  output logic signed [ERR_W-1:0] err_d2
);

  logic signed [ERR_W-1:0] e1_q, e2_q;
  logic signed [ERR_W-1:0] e1_d, e2_d;

  // Signed error, one bit wider than the amplitude.
  assign err_now = $signed({1'b0, target}) - $signed({1'b0, amp});

  always_comb begin
    e1_d = e1_q;
    e2_d = e2_q;
    if (upd) begin
      e1_d = err_now;
      e2_d = e1_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      e1_q <= '0;
      e2_q <= '0;
    end else if (upd) begin
      e1_q <= e1_d;
      e2_q <= e2_d;
    end
  end

  assign err_d1 = e1_q;
  assign err_d2 = e2_q;

endmodule

// File: rtl/agc_pid_delta.sv
module agc_pid_delta
  import agc_pid_pkg::*;
#(
  parameter int unsigned ERR_W   = 17,
  parameter int unsigned SHIFT_W = 4,
  parameter int unsigned DLT_W   = ERR_W + 4
) (
  input  logic signed [ERR_W-1:0] err_now,
  input  logic signed [ERR_W-1:0] err_d1,
  input  logic signed [ERR_W-1:0] err_d2,
  input  logic [SHIFT_W-1:0]      kp_shift,
  input  logic [SHIFT_W-1:0]      ki_shift,
  input  logic [SHIFT_W-1:0]      kd_shift,
  output logic signed [DLT_W-1:0] delta
);

  // A second difference spans up to four error magnitudes.
  localparam int unsigned TW = sum4_width(ERR_W);

  logic signed [TW-1:0]    e0_x, e1_x, e2_x;
  logic signed [TW-1:0]    raw    [NUM_TERMS];
  logic [SHIFT_W-1:0]      sh     [NUM_TERMS];
  logic signed [TW-1:0]    scaled [NUM_TERMS];
  logic signed [DLT_W-1:0] acc;

  assign e0_x = TW'(err_now);
  assign e1_x = TW'(err_d1);
  assign e2_x = TW'(err_d2);

  // Term 0 is the first difference, term 1 the level, term 2 the second difference.
  always_comb begin
    raw[0] = e0_x - e1_x;
    raw[1] = e0_x;
    raw[2] = e0_x - (e1_x <<< 1) + e2_x;
    sh[0]  = kp_shift;
    sh[1]  = ki_shift;
    sh[2]  = kd_shift;
  end

  for (genvar t = 0; t < NUM_TERMS; t++) begin : g_term
    assign scaled[t] = raw[t] >>> sh[t];
  end

  always_comb begin
    acc = '0;
    for (int t = 0; t < NUM_TERMS; t++) begin
      acc = acc + DLT_W'(scaled[t]);
    end
  end

  assign delta = acc;

endmodule

// File: rtl/agc_gain_acc.sv
module agc_gain_acc
  import agc_pid_pkg::*;
#(
  parameter int unsigned GAIN_W = 16,
  parameter int unsigned DLT_W  = 21
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    upd,
  input  logic signed [DLT_W-1:0] delta,
  input  logic [GAIN_W-1:0]       gain_init,
  input  logic [GAIN_W-1:0]       gain_min,
  input  logic [GAIN_W-1:0]       gain_max,
  output logic [GAIN_W-1:0]       gain_out,
  output logic                    init_done
);

  localparam int unsigned BASE_W = GAIN_W + 1;
  localparam int unsigned SUM_W  = ((BASE_W > DLT_W) ? BASE_W : DLT_W) + 1;
  localparam int unsigned PAD_W  = SUM_W - GAIN_W;

  logic [GAIN_W-1:0]       gain_q, gain_d;
  logic                    init_q, init_d;
  logic [GAIN_W-1:0]       base;
  logic signed [SUM_W-1:0] sum, hi, lo;
  acc_act_e                act;

  assign base = init_q ? gain_q : gain_init;
  assign sum  = $signed({{PAD_W{1'b0}}, base}) + SUM_W'(delta);
  assign hi   = $signed({{PAD_W{1'b0}}, gain_max});
  assign lo   = $signed({{PAD_W{1'b0}}, gain_min});

  always_comb begin
    if (!upd) begin
      act = init_q ? ACC_IDLE : ACC_LOAD;
    end else if ((base >= gain_max) && (delta > 0)) begin
      act = ACC_HOLD;
    end else if ((base <= gain_min) && (delta < 0)) begin
      act = ACC_HOLD;
    end else if (sum > hi) begin
      act = ACC_CLAMP_HI;
    end else if (sum < lo) begin
      act = ACC_CLAMP_LO;
    end else begin
      act = ACC_ADD;
    end
  end

  always_comb begin
    init_d = 1'b1;
    unique case (act)
      ACC_IDLE:     gain_d = gain_q;
      ACC_LOAD:     gain_d = gain_init;
      ACC_HOLD:     gain_d = base;
      ACC_CLAMP_HI: gain_d = gain_max;
      ACC_CLAMP_LO: gain_d = gain_min;
      ACC_ADD:      gain_d = sum[GAIN_W-1:0];
      default:      gain_d = gain_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gain_q <= '0;
      init_q <= 1'b0;
    end else begin
      gain_q <= gain_d;
      init_q <= init_d;
    end
  end

  assign gain_out  = init_q ? gain_q : gain_init;
  assign init_done = init_q;

endmodule

// File: rtl/agc_pid_ctrl.sv
module agc_pid_ctrl #(
  parameter int unsigned AMP_W   = 16,
  parameter int unsigned GAIN_W  = 16,
  parameter int unsigned SHIFT_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               amp_valid,
  input  logic [AMP_W-1:0]   amp_in,
  input  logic [AMP_W-1:0]   target,
  input  logic [SHIFT_W-1:0] kp_shift,
  input  logic [SHIFT_W-1:0] ki_shift,
  input  logic [SHIFT_W-1:0] kd_shift,
  input  logic [GAIN_W-1:0]  gain_init,
  input  logic [GAIN_W-1:0]  gain_min,
  input  logic [GAIN_W-1:0]  gain_max,
  output logic [GAIN_W-1:0]  gain_out
);

  localparam int unsigned ERR_W = AMP_W + 1;
  localparam int unsigned DLT_W = ERR_W + 4;

  logic signed [ERR_W-1:0] err_now, err_d1, err_d2;
  logic signed [DLT_W-1:0] pid_delta;
  logic                    init_done;

  agc_err_hist #(
    .AMP_W (AMP_W),
    .ERR_W (ERR_W)
  ) u_hist (
    .clk     (clk),
    .rst_n   (rst_n),
    .upd     (amp_valid),
    .amp     (amp_in),
    .target  (target),
    .err_now (err_now),
    .err_d1  (err_d1),
    .err_d2  (err_d2)
  );

  agc_pid_delta #(
    .ERR_W   (ERR_W),
    .SHIFT_W (SHIFT_W),
    .DLT_W   (DLT_W)
  ) u_delta (
    .err_now  (err_now),
    .err_d1   (err_d1),
    .err_d2   (err_d2),
    .kp_shift (kp_shift),
    .ki_shift (ki_shift),
    .kd_shift (kd_shift),
    .delta    (pid_delta)
  );

  agc_gain_acc #(
    .GAIN_W (GAIN_W),
    .DLT_W  (DLT_W)
  ) u_acc (
    .clk       (clk),
    .rst_n     (rst_n),
    .upd       (amp_valid),
    .delta     (pid_delta),
    .gain_init (gain_init),
    .gain_min  (gain_min),
    .gain_max  (gain_max),
    .gain_out  (gain_out),
    .init_done (init_done)
  );

endmodule

// File: rtl/agc_pid_ctrl_chk.sv
module agc_pid_ctrl_chk #(
  parameter int unsigned GAIN_W = 16,
  parameter int unsigned DLT_W  = 21
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    amp_valid,
  input logic [GAIN_W-1:0]       gain_init,
  input logic [GAIN_W-1:0]       gain_min,
  input logic [GAIN_W-1:0]       gain_max,
  input logic [GAIN_W-1:0]       gain_out,
  input logic signed [DLT_W-1:0] delta,
  input logic                    init_done
);

  logic past_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;
  end

  // R1: before the first update the initial value is presented
  a_r1_init_gain: assert property (@(posedge clk) disable iff (!rst_n)
    !init_done |-> gain_out == gain_init);

  // R2: no strobe, no change
  a_r2_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok && !$past(amp_valid) && $past(init_done) |-> gain_out == $past(gain_out));

  // R7: an update never moves the gain above the upper limit
  a_r7_upper_limit: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok && $past(amp_valid) |->
      (gain_out <= $past(gain_max)) || (gain_out == $past(gain_out)));

  // R8: an update never moves the gain below the lower limit
  a_r8_lower_limit: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok && $past(amp_valid) |->
      (gain_out >= $past(gain_min)) || (gain_out == $past(gain_out)));

  // R9: a positive increment at the upper limit leaves the gain unchanged
  a_r9_stop_high: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok && $past(amp_valid) && $past(init_done) &&
    ($past(gain_out) >= $past(gain_max)) && ($past(delta) > 0)
      |-> gain_out == $past(gain_out));

  // R9: a negative increment at the lower limit leaves the gain unchanged
  a_r9_stop_low: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok && $past(amp_valid) && $past(init_done) &&
    ($past(gain_out) <= $past(gain_min)) && ($past(delta) < 0)
      |-> gain_out == $past(gain_out));

endmodule

bind agc_pid_ctrl agc_pid_ctrl_chk #(
  .GAIN_W (GAIN_W),
  .DLT_W  (DLT_W)
) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .amp_valid (amp_valid),
  .gain_init (gain_init),
  .gain_min  (gain_min),
  .gain_max  (gain_max),
  .gain_out  (gain_out),
  .delta     (pid_delta),
  .init_done (init_done)
);

// File: tb/agc_pid_ctrl_tb_top.sv
module agc_pid_ctrl_tb_top;

  localparam int AW = 8;
  localparam int GW = 10;
  localparam int SW = 4;

  logic          clk;
  logic          rst_n;
  logic          amp_valid;
  logic [AW-1:0] amp_in, target;
  logic [SW-1:0] kp_shift, ki_shift, kd_shift;
  logic [GW-1:0] gain_init, gain_min, gain_max;
  logic [GW-1:0] gain_out;

  int checks;
  int errors;
  bit done;

  // Reference state, derived from the requirements
  int m_gain, m_e1, m_e2;

  agc_pid_ctrl #(.AMP_W(AW), .GAIN_W(GW), .SHIFT_W(SW)) dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .amp_valid (amp_valid),
    .amp_in    (amp_in),
    .target    (target),
    .kp_shift  (kp_shift),
    .ki_shift  (ki_shift),
    .kd_shift  (kd_shift),
    .gain_init (gain_init),
    .gain_min  (gain_min),
    .gain_max  (gain_max),
    .gain_out  (gain_out)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic check(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  function automatic int model_delta(input int e);
    int dp, di, dd;
    dp = (e - m_e1) >>> kp_shift;
    di = e >>> ki_shift;
    dd = (e - 2 * m_e1 + m_e2) >>> kd_shift;
    return dp + di + dd;
  endfunction

  function automatic int model_next(input int g, input int d);
    int mx, mn;
    mx = int'(gain_max);
    mn = int'(gain_min);
    if (g >= mx && d > 0) return g;
    if (g <= mn && d < 0) return g;
    if (g + d > mx) return mx;
    if (g + d < mn) return mn;
    return g + d;
  endfunction

  task automatic do_reset(input int init);
    @(negedge clk);
    rst_n = 1'b0;
    amp_valid = 1'b0;
    gain_init = GW'(init);
    repeat (3) @(negedge clk);
    check("R1 gain during reset", int'(gain_out), init);
    rst_n = 1'b1;
    m_gain = init;
    m_e1 = 0;
    m_e2 = 0;
    @(negedge clk);
    check("R1 gain after release", int'(gain_out), init);
  endtask

  // One accepted sample; checks the R6 timing and the R3/R4/R5 arithmetic.
  task automatic apply(input int amp, input string tag);
    int e, d;
    @(negedge clk);
    amp_in = AW'(amp);
    amp_valid = 1'b1;
    #1;
    check({"R6 no change before edge ", tag}, int'(gain_out), m_gain);
    e = int'(target) - amp;
    d = model_delta(e);
    m_gain = model_next(m_gain, d);
    m_e2 = m_e1;
    m_e1 = e;
    @(negedge clk);
    amp_valid = 1'b0;
    check({"R4 gain after sample ", tag}, int'(gain_out), m_gain);
  endtask

  task automatic t_reset_state();
    do_reset(512);
    // R1: a zero-error sample leaves history terms at zero, so gain stays
    apply(100, "R1 zero history");
    check("R1 history cleared", int'(gain_out), 512);
  endtask

  task automatic t_small_steps();
    apply(90,  "R3 below target");
    apply(110, "R3 above target");
    apply(130, "R3 far above");
    apply(70,  "R4 far below");
    apply(100, "R4 settle");
    apply(101, "R4 rounding neg");
  endtask

  task automatic t_idle_hist();
    int g0;
    apply(60, "R5 first");
    g0 = m_gain;
    amp_in = AW'(7);
    repeat (6) begin
      @(negedge clk);
      check("R2 idle hold", int'(gain_out), g0);
    end
    apply(60, "R5 history after idle");
    apply(140, "R5 history shift");
  endtask

  task automatic t_sat_max();
    for (int i = 0; i < 40; i++) apply(0, "R7 climb");
    check("R7 pinned at max", int'(gain_out), int'(gain_max));
    apply(0, "R9 hold at max");
    check("R9 stays at max", int'(gain_out), int'(gain_max));
    apply(230, "R9 leave max");
    check("R9 moved off max", int'(gain_out < gain_max), 1);
  endtask

  task automatic t_sat_min();
    for (int i = 0; i < 60; i++) apply(255, "R8 fall");
    check("R8 pinned at min", int'(gain_out), int'(gain_min));
    apply(255, "R9 hold at min");
    check("R9 stays at min", int'(gain_out), int'(gain_min));
    apply(0, "R9 leave min");
    check("R9 moved off min", int'(gain_out > gain_min), 1);
  endtask

  task automatic t_reset_reload();
    apply(20, "R5 prime history");
    do_reset(300);
    apply(100, "R1 reload zero error");
    check("R1 reloaded gain", int'(gain_out), 300);
    apply(80, "R1 fresh history");
  endtask

  initial begin
    checks = 0;
    errors = 0;
    done = 1'b0;
    rst_n = 1'b0;
    amp_valid = 1'b0;
    amp_in = '0;
    target = AW'(100);
    kp_shift = SW'(1);
    ki_shift = SW'(2);
    kd_shift = SW'(2);
    gain_init = GW'(512);
    gain_min = GW'(64);
    gain_max = GW'(900);
    t_reset_state();
    t_small_steps();
    t_idle_hist();
    t_sat_max();
    t_sat_min();
    t_reset_reload();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule